// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. On a start pulse it clears the external integrator, connects the unknown input to it for a fixed window of clocks, then swaps in the reference of opposite polarity. From that point it counts clocks until the external comparator reports that the integrator is back at its starting level. The count at that moment is the conversion result.

The fixed run-up window is 2^N clocks, where N is the result width. A run-down count of 2^N therefore corresponds to an input equal to the reference. The result depends only on the ratio of input to reference. The integrator's gain or time constant cancels out, because the same integrator sets both slopes.

A conversion lasts a fixed part plus a part that grows with the input amplitude. The result register updates once per conversion and is marked by a one-clock `done` pulse. An input too large to run down in 2^N clocks saturates the result and raises a flag.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset and whenever idle, `integ_rst` is 1, `conn_in` and `conn_ref` are 0, and `busy` and `done` are 0.
- R2: A `start` sampled high while idle is followed by exactly one arming clock. In that clock `integ_rst` is 0 and both switch controls are 0. Run-up begins on the next clock.
- R3: During run-up only `conn_in` is 1, and it stays 1 for exactly 2^N consecutive clocks.
- R4: During run-down only `conn_ref` is 1. Number the run-down clocks from 0. The result is the number k of the first run-down clock in which `cmp_trip` is sampled 1, and the run-down ends at that clock.
- R5: The result equals ceil(vin·2^N / vref) for any positive integrator gain. It depends only on the ratio of input to reference.
- R6: If `cmp_trip` stays 0 for all 2^N run-down clocks, `result` becomes all ones and `overrange` becomes 1.
- R7: `done` is high for exactly one clock, in the same clock in which `result` and `overrange` take their new values. A conversion that ends by a comparator trip clears `overrange`.
- R8: A `start` pulse received while `busy` is 1 has no effect. The conversion in progress gives the same result and the same timing, and it produces only one `done`.
- R9: `done` is seen high 2^N + 2 + k clock edges after the edge that sampled `start`. Here k is the result, or 2^N − 1 on overrange.
- R10: `conn_in` and `conn_ref` are never 1 together, and neither is 1 while `integ_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a conversion; ignored while busy |
| cmp_trip | input | 1 | Comparator: 1 when the integrator is at or below its starting level |
| integ_rst | output | 1 | Holds the integrator cleared when 1 |
| conn_in | output | 1 | Closes the switch from the unknown input to the integrator |
| conn_ref | output | 1 | Closes the switch from the reference to the integrator |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-clock pulse when the result updates |
| overrange | output | 1 | Last result saturated because the comparator never tripped |
| result | output | N | Run-down clock count of the last conversion |

## Verification
The bench uses a behavioural integrator and drives conversions with several inputs. A zero input checks that a trip in the first run-down clock gives code 0. The inputs just under and just over full scale separate the largest valid code from the saturated, overrange one. A larger overrange input and a normal conversion that follows it show whether the flag clears. The same input is converted under two integrator gains and two reference levels. This shows that the count follows the input-to-reference ratio and not the slope. Each conversion's latency is also compared against its result, so errors that shift the count by one clock are caught. A start pulse sent in the middle of a run-up shows whether the block really ignores it.

// File: rtl/dsc_pkg.sv
// Shared types for the dual-slope conversion sequencer.
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUNUP = 2'd2,
        ST_RUNDN = 2'd3
    } dsc_state_e;
endpackage

// File: rtl/dsc_clock_counter.sv
// Clock counter shared by run-up and run-down.
// Assumes: clear has priority over enable; at_max flags the all-ones value.
module dsc_clock_counter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    output logic [N-1:0] count,
    output logic         at_max
);
    localparam logic [N-1:0] CNT_MAX = '1;

    // Count held clocks, restarting from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (enable)
            count <= count + 1'b1;
    end

    // Terminal value of the window.
    assign at_max = (count == CNT_MAX);
endmodule

// File: rtl/dsc_phase_ctrl.sv
// Phase sequencer: idle -> arm -> run-up -> run-down -> idle.
// Assumes: the counter reads zero on the first clock of each timed phase.
// It requests a result capture on a comparator trip or on run-down timeout.
module dsc_phase_ctrl
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmp_trip,
    input  logic       at_max,
    output dsc_state_e state,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       capture,
    output logic       capture_ovr
);
    dsc_state_e state_nx;

    // Next-state and counter control decode.
    always_comb begin
        state_nx    = state;
        cnt_clr     = 1'b0;
        cnt_en      = 1'b0;
        capture     = 1'b0;
        capture_ovr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (start) state_nx = ST_ARM;
            end
            ST_ARM: begin
                cnt_clr  = 1'b1;
                state_nx = ST_RUNUP;
            end
            ST_RUNUP: begin
                if (at_max) begin
                    cnt_clr  = 1'b1;
                    state_nx = ST_RUNDN;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_RUNDN: begin
                if (cmp_trip) begin
                    capture  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (at_max) begin
                    capture     = 1'b1;
                    capture_ovr = 1'b1;
                    state_nx    = ST_IDLE;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/dsc_result_reg.sv
// Result latch: stores the run-down count, or all ones with the overrange flag.
// Assumes: capture is a single-clock request from the sequencer.
module dsc_result_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         capture_ovr,
    input  logic [N-1:0] count,
    output logic [N-1:0] result,
    output logic         overrange,
    output logic         done
);
    // Latch the result and flag on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (capture) begin
            result    <= capture_ovr ? '1 : count;
            overrange <= capture_ovr;
        end
    end

    // One-clock completion strobe aligned with the result update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= capture;
    end
endmodule

// File: rtl/dual_slope_seq.sv
// Top of the dual-slope conversion sequencer.
// Assumes: the comparator output is synchronous to clk and is 1 once the
// integrator has returned to or passed its starting level.
// Switch and reset controls decode directly from the phase.
module dual_slope_seq
    import dsc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_trip,
    output logic         integ_rst,
    output logic         conn_in,
    output logic         conn_ref,
    output logic         busy,
    output logic         done,
    output logic         overrange,
    output logic [N-1:0] result
);
    dsc_state_e   state;
    logic         cnt_clr;
    logic         cnt_en;
    logic         capture;
    logic         capture_ovr;
    logic [N-1:0] count;
    logic         at_max;

    dsc_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmp_trip    (cmp_trip),
        .at_max      (at_max),
        .state       (state),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .capture     (capture),
        .capture_ovr (capture_ovr)
    );

    dsc_clock_counter #(.N(N)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clr),
        .enable (cnt_en),
        .count  (count),
        .at_max (at_max)
    );

    dsc_result_reg #(.N(N)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .capture_ovr (capture_ovr),
        .count       (count),
        .result      (result),
        .overrange   (overrange),
        .done        (done)
    );

    // Analog control outputs decoded from the phase.
    always_comb begin
        integ_rst = (state == ST_IDLE);
        conn_in   = (state == ST_RUNUP);
        conn_ref  = (state == ST_RUNDN);
        busy      = (state != ST_IDLE);
    end
endmodule

// File: rtl/dual_slope_seq_chk.sv
// Property checker for dual_slope_seq, bound to every instance.
// Assumes: observes ports only; the run-up length is measured with a counter.
module dual_slope_seq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         cmp_trip,
    input logic         integ_rst,
    input logic         conn_in,
    input logic         conn_ref,
    input logic         busy,
    input logic         done,
    input logic         overrange,
    input logic [N-1:0] result
);
    localparam int WIN = 1 << N;

    logic [N:0] runlen;

    // Length of the current or most recent run-up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            runlen <= '0;
        else if (conn_in)
            runlen <= runlen + 1'b1;
        else
            runlen <= '0;
    end

    p_switch_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(conn_in && conn_ref));
    p_reset_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        integ_rst |-> (!conn_in && !conn_ref));
    p_arm_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!integ_rst && !conn_in && !conn_ref && busy));
    p_runup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn_in) |-> (runlen == (N+1)'(WIN)));
    p_trip_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_ref && cmp_trip) |=> (done && !conn_ref && !overrange));
    p_ovr_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (&result));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && integ_rst));
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conn_ref && start) |=> busy);
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmp_trip  (cmp_trip),
    .integ_rst (integ_rst),
    .conn_in   (conn_in),
    .conn_ref  (conn_ref),
    .busy      (busy),
    .done      (done),
    .overrange (overrange),
    .result    (result)
);

// File: tb/test_dual_slope_seq.sv
// Scoreboard bench with a behavioural integrator and comparator.
module test_dual_slope_seq;
    localparam int N = 8;
    localparam int P = 1 << N;

    typedef struct {
        int exp_res;
        bit exp_ovr;
        int exp_lat;
        int start_cyc;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_trip;
    logic         integ_rst, conn_in, conn_ref, busy, done, overrange;
    logic [N-1:0] result;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int vin = 0, vref = P, gain = 1;
    longint acc = 0;
    item_t sb[$];
    int ndone = 0;
    bit prev_done = 0;
    int uplen = 0;
    bit finished = 0;

    dual_slope_seq #(.N(N)) i_dual_slope_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_trip(cmp_trip),
        .integ_rst(integ_rst), .conn_in(conn_in), .conn_ref(conn_ref),
        .busy(busy), .done(done), .overrange(overrange), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Integrator model: cleared by integ_rst, otherwise sums the switched inputs.
    always @(posedge clk) begin
        if (integ_rst)
            acc <= 0;
        else
            acc <= acc + longint'(gain) * ((conn_in ? vin : 0) - (conn_ref ? vref : 0));
    end
    assign cmp_trip = (acc <= 0);

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor: pops expected items on done, checks pulse width and switch use.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conn_in && conn_ref) check(0, "R10 both switches", 1, 0);
            if (conn_in) uplen++;
            else if (uplen != 0) begin
                check(uplen == P, "R3 run-up length", uplen, P);
                uplen = 0;
            end
            if (prev_done && done) check(0, "R7 done width", 2, 1);
            if (done && !prev_done) begin
                ndone++;
                if (sb.size() == 0) check(0, "R8 unexpected done", 1, 0);
                else begin
                    item_t it;
                    it = sb.pop_front();
                    check(int'(result) == it.exp_res, {it.tag, " result"}, int'(result), it.exp_res);
                    check(overrange == it.exp_ovr, {"R6 R7 overrange ", it.tag}, int'(overrange), int'(it.exp_ovr));
                    check(cyc - it.start_cyc == it.exp_lat, {"R9 latency ", it.tag}, cyc - it.start_cyc, it.exp_lat);
                end
            end
            prev_done = done;
        end
    end

    // Driver: computes the expected result, pushes it, and pulses start.
    task automatic convert(input int v, input int r, input int g, input string tag,
                           input bit poke, input bit chk_arm);
        item_t it;
        int c;
        while (busy) @(negedge clk);
        @(negedge clk);
        vin = v; vref = r; gain = g;
        c = (v * P + r - 1) / r;
        if (c > P - 1) begin
            it.exp_res = P - 1; it.exp_ovr = 1; c = P - 1;
        end else begin
            it.exp_res = c; it.exp_ovr = 0;
        end
        it.exp_lat = P + 3 + c;
        it.start_cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (chk_arm) begin
            check(!integ_rst && !conn_in && !conn_ref, "R2 arm clock", int'(integ_rst), 0);
            @(negedge clk);
            check(conn_in && !conn_ref, "R2 run-up follows arm", int'(conn_in), 1);
        end
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(integ_rst && !conn_in && !conn_ref && !busy, "R1 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(integ_rst && !conn_in && !conn_ref && !busy && !done,
              "R1 reset state", int'({integ_rst, conn_in, conn_ref, busy, done}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        convert(0,   P,     1, "R4 zero",          0, 1);
        convert(100, P,     1, "R4 mid",           0, 0);
        convert(P-1, P,     1, "R4 top code",      0, 0);
        convert(P,   P,     1, "R6 full scale",    0, 0);
        convert(400, P,     1, "R6 overrange",     0, 0);
        convert(1,   P,     1, "R7 clear ovr",     0, 0);
        convert(100, 2*P,   1, "R5 ref x2",        0, 0);
        convert(100, 2*P,   7, "R5 gain x7",       0, 0);
        convert(37,  100,   3, "R5 ratio",         0, 0);
        convert(60,  P,     1, "R8 busy start",    1, 0);
        repeat (20) @(negedge clk);
        check(ndone == 10, "R8 done count", ndone, 10);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule